// File: doc/BRIEF.md
# Character LCD Host Command Interface

This block sits between a microprocessor bus and the storage and scanning logic of a character LCD controller. The host drives a strobe, a register-select line, a read/write line and an 8-bit data bus. The block samples these lines when the strobe falls, after the strobe has been synchronised to the system clock. The bus runs either as a full byte or as two 4-bit transfers on the upper four data lines. Each completed byte is either an instruction, a data write, a data read or a status read.

The block decodes each instruction from the position of its highest set bit. It keeps the display flags and one 7-bit address counter that serves both the display RAM and the glyph RAM. It issues write and read strobes, with address and data, to RAM outside the block. Every accepted access starts a down-counter that holds the busy flag high for a number of system-clock cycles set by a parameter for each instruction class. A short settling gap follows, during which the busy flag is already low but nothing new is accepted. The host polls the busy flag and the address counter with status reads, which are served at any time.

Top module: `lcd_cmd_if`

## Requirements
- R1: While reset is held and for exactly INIT_CYC clock cycles after it is released, `busy` is 1; it is 0 from the following cycle. After reset the block is in 8-bit mode, increment is selected, shift-on-write is off, display, cursor and blink are off, 1-line and short-font are selected, and the address counter is 0 in display RAM.
- R2: A status read (rs=0, rw=1) drives `{busy, address[6:0]}` on `bus_dout` while `bus_e` is high, with `bus_oe` high. It is served even while busy and changes no state.
- R3: Instruction `1aaaaaaa` loads the address counter with `aaaaaaa` and selects display RAM. Instruction `01aaaaaa` loads `{0,aaaaaa}` and selects glyph RAM (`ram_sel_cg`=1), where the address stays within 6 bits.
- R4: A data write (rs=1, rw=0) pulses `ram_we` for one cycle with `ram_addr` equal to the counter and `ram_wdata` equal to the byte. The counter then moves +1 when increment is selected and -1 otherwise, wrapping at 7 bits in display RAM and at 6 bits in glyph RAM.
- R5: A data read (rs=1, rw=1) puts `ram_rdata` at the current counter on `bus_dout`, pulses `ram_re` when the byte completes, and moves the counter as in R4.
- R6: Instructions `00000001` and `0000001x` return the counter to 0 and select display RAM.
- R7: `000001 I S` sets increment (I, bit 1) and shift-on-write (S, bit 0). `00001 D C B` sets display (bit 2), cursor (bit 1) and blink (bit 0). `001 L N F xx` sets 8-bit mode (L, bit 4), 2-line (N, bit 3) and tall font (F, bit 2). `00000000` does nothing and does not raise busy.
- R8: `0001 S R xx` with S (bit 3)=0 moves the counter +1 when R (bit 2)=1 and -1 otherwise. With S=1 it pulses `scroll_req` with `scroll_right`=R and leaves the counter unchanged.
- R9: A data write while shift-on-write is set pulses `scroll_req`, with `scroll_right` equal to the inverse of increment.
- R10: After an accepted access, `busy` is high for exactly LONG_CYC cycles (R6 instructions), SHORT_CYC cycles (all other instructions) or DATA_CYC cycles (data write or read). A further GAP_CYC cycles follow with `busy` low in which accesses are still refused.
- R11: Instruction writes, data writes and data reads that complete while busy or in the gap are ignored: no strobe and no change of state.
- R12: In 4-bit mode the high nibble comes first on `bus_din[7:4]` and the low nibble second; `bus_din[3:0]` is ignored. Reads give the high nibble on `bus_dout[7:4]` in the first transfer and the low nibble there in the second. Any change of the mode puts the nibble phase back to high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_e | input | 1 | Host strobe; sampled on its falling edge |
| bus_rs | input | 1 | 0 = instruction/status, 1 = data |
| bus_rw | input | 1 | 0 = write, 1 = read |
| bus_din | input | 8 | Host data in |
| bus_dout | output | 8 | Host data out |
| bus_oe | output | 1 | Output enable for the host data pads |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read-consumed strobe |
| ram_sel_cg | output | 1 | 1 = glyph RAM, 0 = display RAM |
| ram_addr | output | 7 | RAM address (the address counter) |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data at `ram_addr` (combinational) |
| busy | output | 1 | Busy flag |
| inc_mode | output | 1 | Address counter increments |
| shift_on_write | output | 1 | Display shifts on each write |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Cursor blink enable |
| if_8bit | output | 1 | 8-bit bus mode |
| two_line | output | 1 | 2-line display |
| tall_font | output | 1 | Tall glyph format |
| scroll_req | output | 1 | One-cycle display shift request |
| scroll_right | output | 1 | Direction of the last shift request |

## Verification
The hardest situation to reach from the ports is an access that lands after the busy flag has already dropped but before the settling gap has ended. A host that polls correctly never produces it. The bench enlarges the gap through a parameter, waits for `busy` to fall, and starts a transfer at once, so the strobe falls while the counter is still nonzero. It then shows that the address counter did not move. The nibble phase after a change of bus mode is reached by switching to 4-bit mode and back and then sending a single 8-bit instruction.

// File: rtl/lcd_cmd_if.sv
module lcd_cmd_if #(
  parameter int INIT_CYC  = 40,
  parameter int LONG_CYC  = 410,
  parameter int SHORT_CYC = 10,
  parameter int DATA_CYC  = 12,
  parameter int GAP_CYC   = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_e,
  input  logic       bus_rs,
  input  logic       bus_rw,
  input  logic [7:0] bus_din,
  output logic [7:0] bus_dout,
  output logic       bus_oe,
  output logic       ram_we,
  output logic       ram_re,
  output logic       ram_sel_cg,
  output logic [6:0] ram_addr,
  output logic [7:0] ram_wdata,
  input  logic [7:0] ram_rdata,
  output logic       busy,
  output logic       inc_mode,
  output logic       shift_on_write,
  output logic       disp_on,
  output logic       cursor_on,
  output logic       blink_on,
  output logic       if_8bit,
  output logic       two_line,
  output logic       tall_font,
  output logic       scroll_req,
  output logic       scroll_right
);

  localparam int CW = $clog2(INIT_CYC + LONG_CYC + SHORT_CYC + DATA_CYC + GAP_CYC + 1);

  logic          e_s1, e_s2, e_d;
  logic          lo_phase;
  logic [3:0]    hi_nib;
  logic [CW-1:0] cnt, load;
  logic [6:0]    ac;
  logic [7:0]    byte_in, rd_byte;
  logic          fall, done, go, cmd, dwr, drd;

  function automatic logic [6:0] stepped(input logic [6:0] a, input logic up, input logic cgm);
    logic [6:0] n;
    n = up ? a + 7'd1 : a - 7'd1;
    return cgm ? {1'b0, n[5:0]} : n;
  endfunction

  assign fall    = e_d & ~e_s2;
  assign done    = fall & (if_8bit | lo_phase);
  assign byte_in = if_8bit ? bus_din : {hi_nib, bus_din[7:4]};
  assign go      = done & (cnt == '0) & ~(~bus_rs & bus_rw);
  assign cmd     = go & ~bus_rs & ~bus_rw;
  assign dwr     = go & bus_rs & ~bus_rw;
  assign drd     = go & bus_rs & bus_rw;

  assign ram_we    = dwr;
  assign ram_re    = drd;
  assign ram_wdata = byte_in;
  assign ram_addr  = ac;
  assign busy      = cnt > CW'(GAP_CYC);

  assign rd_byte  = bus_rs ? ram_rdata : {busy, ac};
  assign bus_dout = (if_8bit | ~lo_phase) ? rd_byte : {rd_byte[3:0], 4'b0000};
  assign bus_oe   = bus_e & bus_rw;

  always_comb begin
    load = '0;
    if (dwr || drd)
      load = CW'(DATA_CYC + GAP_CYC);
    else if (cmd) begin
      if (|byte_in[7:2])      load = CW'(SHORT_CYC + GAP_CYC);
      else if (|byte_in[1:0]) load = CW'(LONG_CYC + GAP_CYC);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_s1 <= 1'b0;
      e_s2 <= 1'b0;
      e_d  <= 1'b0;
    end else begin
      e_s1 <= bus_e;
      e_s2 <= e_s1;
      e_d  <= e_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= CW'(INIT_CYC + GAP_CYC);
    else if (load != '0)
      cnt <= load;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_phase       <= 1'b0;
      hi_nib         <= 4'h0;
      ac             <= 7'h00;
      ram_sel_cg     <= 1'b0;
      inc_mode       <= 1'b1;
      shift_on_write <= 1'b0;
      disp_on        <= 1'b0;
      cursor_on      <= 1'b0;
      blink_on       <= 1'b0;
      if_8bit        <= 1'b1;
      two_line       <= 1'b0;
      tall_font      <= 1'b0;
      scroll_req     <= 1'b0;
      scroll_right   <= 1'b0;
    end else begin
      scroll_req <= 1'b0;
      if (fall && !if_8bit) begin
        lo_phase <= ~lo_phase;
        if (!lo_phase) hi_nib <= bus_din[7:4];
      end
      if (dwr || drd)
        ac <= stepped(ac, inc_mode, ram_sel_cg);
      if (dwr && shift_on_write) begin
        scroll_req   <= 1'b1;
        scroll_right <= ~inc_mode;
      end
      if (cmd) begin
        casez (byte_in)
          8'b1???????: begin
            ac         <= byte_in[6:0];
            ram_sel_cg <= 1'b0;
          end
          8'b01??????: begin
            ac         <= {1'b0, byte_in[5:0]};
            ram_sel_cg <= 1'b1;
          end
          8'b001?????: begin
            if_8bit   <= byte_in[4];
            two_line  <= byte_in[3];
            tall_font <= byte_in[2];
            if (byte_in[4] != if_8bit) lo_phase <= 1'b0;
          end
          8'b0001????: begin
            if (byte_in[3]) begin
              scroll_req   <= 1'b1;
              scroll_right <= byte_in[2];
            end else
              ac <= stepped(ac, byte_in[2], ram_sel_cg);
          end
          8'b00001???: begin
            disp_on   <= byte_in[2];
            cursor_on <= byte_in[1];
            blink_on  <= byte_in[0];
          end
          8'b000001??: begin
            inc_mode       <= byte_in[1];
            shift_on_write <= byte_in[0];
          end
          8'b0000001?, 8'b00000001: begin
            ac         <= 7'h00;
            ram_sel_cg <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  AST_WRITE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> busy); // R10
  AST_NO_STROBE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(ram_we || ram_re)); // R11
  AST_GLYPH_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel_cg |-> !ram_addr[6]); // R3
  AST_WRITE_STEPS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && inc_mode && !ram_sel_cg) |=> (ram_addr == $past(ram_addr) + 7'd1)); // R4
  AST_MODE_PHASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (if_8bit != $past(if_8bit)) |-> !lo_phase); // R12

endmodule

// File: tb/lcd_cmd_if_test.sv
module lcd_cmd_if_test;
  localparam int CLK_PERIOD = 10;
  localparam int INIT_C  = 30;
  localparam int LONG_C  = 40;
  localparam int SHORT_C = 10;
  localparam int DATA_C  = 12;
  localparam int GAP_C   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_e = 1'b0, bus_rs = 1'b0, bus_rw = 1'b0;
  logic [7:0] bus_din = 8'h00;
  logic [7:0] bus_dout, ram_wdata, ram_rdata;
  logic [6:0] ram_addr;
  logic bus_oe, ram_we, ram_re, ram_sel_cg, busy;
  logic inc_mode, shift_on_write, disp_on, cursor_on, blink_on;
  logic if_8bit, two_line, tall_font, scroll_req, scroll_right;

  logic [7:0] dd [128];
  logic [7:0] cg [64];
  int nchecks = 0, nerr = 0;
  int run = 0, last_len = 0, we_cnt = 0, re_cnt = 0, sc_cnt = 0;
  logic sc_dir = 1'b0;
  bit finished = 0;

  wire [7:0] flags = {if_8bit, two_line, tall_font, disp_on, cursor_on, blink_on, inc_mode, shift_on_write};

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_cmd_if #(.INIT_CYC(INIT_C), .LONG_CYC(LONG_C), .SHORT_CYC(SHORT_C),
               .DATA_CYC(DATA_C), .GAP_CYC(GAP_C)) uut (
    .clk(clk), .rst_n(rst_n), .bus_e(bus_e), .bus_rs(bus_rs), .bus_rw(bus_rw),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .ram_we(ram_we), .ram_re(ram_re), .ram_sel_cg(ram_sel_cg), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .busy(busy),
    .inc_mode(inc_mode), .shift_on_write(shift_on_write), .disp_on(disp_on),
    .cursor_on(cursor_on), .blink_on(blink_on), .if_8bit(if_8bit),
    .two_line(two_line), .tall_font(tall_font),
    .scroll_req(scroll_req), .scroll_right(scroll_right));

  assign ram_rdata = ram_sel_cg ? cg[ram_addr[5:0]] : dd[ram_addr];

  initial begin
    for (int i = 0; i < 128; i++) dd[i] = 8'h00;
    for (int i = 0; i < 64; i++) cg[i] = 8'h00;
  end

  always @(posedge clk)
    if (ram_we) begin
      if (ram_sel_cg) cg[ram_addr[5:0]] <= ram_wdata;
      else dd[ram_addr] <= ram_wdata;
    end

  always @(negedge clk) begin
    if (busy) run = run + 1;
    else if (run != 0) begin last_len = run; run = 0; end
    if (ram_we) we_cnt = we_cnt + 1;
    if (ram_re) re_cnt = re_cnt + 1;
    if (scroll_req) begin sc_cnt = sc_cnt + 1; sc_dir = scroll_right; end
  end

  // {rs, data byte, expected address counter, expected flags}
  localparam logic [23:0] VEC [20] = '{
    {1'b0, 8'h85, 7'h05, 8'h82}, {1'b0, 8'h0F, 7'h05, 8'h9E},
    {1'b0, 8'h38, 7'h05, 8'hDE}, {1'b0, 8'h14, 7'h06, 8'hDE},
    {1'b0, 8'h10, 7'h05, 8'hDE}, {1'b1, 8'h41, 7'h06, 8'hDE},
    {1'b0, 8'h04, 7'h06, 8'hDC}, {1'b1, 8'h42, 7'h05, 8'hDC},
    {1'b0, 8'h0C, 7'h05, 8'hD0}, {1'b0, 8'h7F, 7'h3F, 8'hD0},
    {1'b0, 8'h06, 7'h3F, 8'hD2}, {1'b1, 8'h1F, 7'h00, 8'hD2},
    {1'b0, 8'hFF, 7'h7F, 8'hD2}, {1'b1, 8'h77, 7'h00, 8'hD2},
    {1'b0, 8'h8A, 7'h0A, 8'hD2}, {1'b0, 8'h03, 7'h00, 8'hD2},
    {1'b0, 8'hCA, 7'h4A, 8'hD2}, {1'b0, 8'h01, 7'h00, 8'hD2},
    {1'b0, 8'h3C, 7'h00, 8'hF2}, {1'b0, 8'h00, 7'h00, 8'hF2}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic rs, input logic rw, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    bus_rs = rs; bus_rw = rw; bus_din = d; bus_e = 1'b1;
    repeat (2) @(negedge clk);
    q = bus_dout;
    @(negedge clk);
    bus_e = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (GAP_C + 2) @(negedge clk);
  endtask

  task automatic op8(input logic rs, input logic rw, input logic [7:0] d, output logic [7:0] q);
    xfer(rs, rw, d, q);
    wait_idle();
  endtask

  task automatic op4(input logic rs, input logic rw, input logic [7:0] d, output logic [7:0] q);
    logic [7:0] q1, q2;
    xfer(rs, rw, {d[7:4], ~d[3:0]}, q1);
    xfer(rs, rw, {d[3:0], ~d[7:4]}, q2);
    q = {q1[7:4], q2[7:4]};
    wait_idle();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchecks++; nerr++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] q;
    int we0, re0, sc0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 1);
    rst_n = 1'b1;
    repeat (INIT_C - 1) @(negedge clk);
    chk("R1 busy last init cycle", busy, 1);
    @(negedge clk);
    chk("R1 busy after init", busy, 0);
    repeat (GAP_C + 2) @(negedge clk);
    chk("R1 reset flags", flags, 8'h82);
    op8(1'b0, 1'b1, 8'h00, q);
    chk("R1 reset status", q, 8'h00);

    for (int i = 0; i < 20; i++) begin
      logic [23:0] v;
      logic [7:0] st;
      int eb;
      v = VEC[i];
      last_len = 0;
      op8(v[23], 1'b0, v[22:15], q);
      chk($sformatf("R7 flags row %0d", i), flags, v[7:0]);
      op8(1'b0, 1'b1, 8'h00, st);
      chk($sformatf("R3 counter row %0d", i), st, {1'b0, v[14:8]});
      if (v[23]) eb = DATA_C;
      else if (v[22:15] >= 8'h04) eb = SHORT_C;
      else eb = LONG_C;
      if (v[23] || v[22:15] != 8'h00)
        chk($sformatf("R10 busy length row %0d", i), last_len, eb);
      else
        chk("R7 no-op leaves busy idle", last_len, 0);
    end
    chk("R4 display write 5", dd[5], 8'h41);
    chk("R4 display write 6", dd[6], 8'h42);
    chk("R4 glyph write 63", cg[63], 8'h1F);
    chk("R4 display write 127", dd[127], 8'h77);

    we0 = we_cnt; re0 = re_cnt;
    op8(1'b0, 1'b1, 8'h00, q);
    op8(1'b0, 1'b1, 8'h00, q);
    chk("R2 status repeat", q, 8'h00);
    chk("R2 status no strobes", (we_cnt - we0) + (re_cnt - re0), 0);
    bus_rs = 1'b0; bus_rw = 1'b1; bus_e = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 output enable", bus_oe, 1);
    bus_e = 1'b0;
    repeat (5) @(negedge clk);

    op8(1'b0, 1'b0, 8'hA0, q);
    op8(1'b1, 1'b0, 8'hA5, q);
    op8(1'b1, 1'b0, 8'h3C, q);
    op8(1'b0, 1'b0, 8'hA0, q);
    re0 = re_cnt;
    last_len = 0;
    op8(1'b1, 1'b1, 8'h00, q);
    chk("R5 read first", q, 8'hA5);
    chk("R10 read busy length", last_len, DATA_C);
    op8(1'b1, 1'b1, 8'h00, q);
    chk("R5 read second", q, 8'h3C);
    chk("R5 read strobes", re_cnt - re0, 2);
    op8(1'b0, 1'b1, 8'h00, q);
    chk("R5 counter after reads", q, 8'h22);

    op8(1'b0, 1'b0, 8'hB0, q);
    xfer(1'b1, 1'b0, 8'h11, q);
    @(negedge clk);
    while (busy) @(negedge clk);
    xfer(1'b0, 1'b0, 8'hD5, q);
    wait_idle();
    op8(1'b0, 1'b1, 8'h00, q);
    chk("R10 gap refuses access", q, 8'h31);

    xfer(1'b0, 1'b0, 8'h90, q);
    xfer(1'b0, 1'b0, 8'hA0, q);
    wait_idle();
    op8(1'b0, 1'b1, 8'h00, q);
    chk("R11 command while busy", q, 8'h10);
    we0 = we_cnt;
    xfer(1'b0, 1'b0, 8'hC0, q);
    xfer(1'b1, 1'b0, 8'h99, q);
    wait_idle();
    chk("R11 data while busy no strobe", we_cnt - we0, 0);
    chk("R11 data while busy ram", dd[8'h40], 8'h00);

    op8(1'b0, 1'b0, 8'h88, q);
    sc0 = sc_cnt;
    op8(1'b0, 1'b0, 8'h1C, q);
    chk("R8 scroll pulse", sc_cnt - sc0, 1);
    chk("R8 scroll right", sc_dir, 1);
    op8(1'b0, 1'b0, 8'h18, q);
    chk("R8 scroll left", sc_dir, 0);
    op8(1'b0, 1'b1, 8'h00, q);
    chk("R8 scroll keeps counter", q, 8'h08);

    op8(1'b0, 1'b0, 8'h07, q);
    op8(1'b0, 1'b0, 8'h04, q);
    op8(1'b0, 1'b0, 8'h07, q);
    sc0 = sc_cnt;
    op8(1'b1, 1'b0, 8'h55, q);
    chk("R9 write scroll pulse", sc_cnt - sc0, 1);
    chk("R9 write scroll dir inc", sc_dir, 0);
    op8(1'b0, 1'b0, 8'h05, q);
    op8(1'b1, 1'b0, 8'h56, q);
    chk("R9 write scroll dir dec", sc_dir, 1);
    op8(1'b0, 1'b0, 8'h06, q);

    op8(1'b0, 1'b0, 8'h45, q);
    op8(1'b0, 1'b0, 8'h01, q);
    op8(1'b1, 1'b0, 8'h66, q);
    chk("R6 clear selects display ram", dd[0], 8'h66);
    chk("R6 glyph untouched", cg[5], 8'h00);

    op8(1'b0, 1'b0, 8'h2C, q);
    chk("R12 enter 4-bit", if_8bit, 0);
    op4(1'b0, 1'b0, 8'h93, q);
    op4(1'b1, 1'b0, 8'h5A, q);
    chk("R12 nibble write", dd[8'h13], 8'h5A);
    op4(1'b0, 1'b1, 8'h00, q);
    chk("R12 nibble status", q, 8'h14);
    op4(1'b0, 1'b0, 8'h93, q);
    op4(1'b1, 1'b1, 8'h00, q);
    chk("R12 nibble read", q, 8'h5A);
    op4(1'b0, 1'b0, 8'h3C, q);
    chk("R12 back to 8-bit", if_8bit, 1);
    op8(1'b0, 1'b0, 8'h87, q);
    op8(1'b0, 1'b1, 8'h00, q);
    chk("R12 phase after mode change", q, 8'h07);

    finished = 1;
    finish_run();
  end
endmodule